// File: doc/BRIEF.md
# Swizzled Four-Channel Vector Adder

This block is the add datapath for a file of wide registers. Every register is 96 bits wide and is split into four 24-bit channels named a, b, c and d. One add instruction names two source registers and one destination register. Each source register passes through its own channel selector, which can reorder and repeat channels freely. The two rearranged operands are added lane by lane, and only the lanes enabled by a destination mask are written back. A computed lane that is masked off is thrown away.

A lane holds either a plain 24-bit two's-complement integer or a signed fixed-point value with 7 integer bits and 16 fraction bits. Both formats go through the same 24-bit adder. The block raises a per-lane flag when a written sum leaves the signed 24-bit range. A second write path loads whole or partial registers from outside, because values cannot enter the file any other way. A combinational debug port reads back any register.

Top module: `swz_vec_adder`

## Requirements
- R1: The file has 32 registers of 96 bits. Channel a is bits [23:0], b is [47:24], c is [71:48] and d is [95:72]. `dbgData` shows register `dbgIdx` combinationally.
- R2: Temporary lane i of a source takes the source channel named by the swizzle bits [2i+1:2i], with code 0=a, 1=b, 2=c and 3=d. A code may appear more than once.
- R3: Result lane i is temporary lane i of source A plus temporary lane i of source B, taken modulo 2^24.
- R4: On a clock edge where `valid` is high, every lane i with `wrMask[i]` set (bit 0 = channel a) takes result lane i in register `dst`. The new value is visible on the debug port after that edge.
- R5: Lanes of `dst` whose mask bit is clear keep their previous contents.
- R6: `ovf[i]` is high in the same cycle as the operands when the signed sum of lane i does not fit in 24 bits, `valid` is high and `wrMask[i]` is set.
- R7: `ovf[i]` stays low while `valid` is low or while `wrMask[i]` is clear, whatever the operands are.
- R8: When `dst` equals a source, that source is read with its value from before the write.
- R9: A synchronous reset with `rst` high clears every register to zero.
- R10: A clock edge with `valid` and `extWr` both low changes no register.
- R11: When `extWr` is high and `valid` is low, each masked lane of `dst` takes the matching lane of `extData`. When both are high, the add wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| valid | input | 1 | Add instruction strobe |
| srcA | input | 5 | First source register index |
| srcB | input | 5 | Second source register index |
| dst | input | 5 | Destination register index |
| swzA | input | 8 | Channel selector for source A |
| swzB | input | 8 | Channel selector for source B |
| wrMask | input | 4 | Destination lane mask, bit 0 = channel a |
| extWr | input | 1 | External load strobe |
| extData | input | 96 | External load data |
| dbgIdx | input | 5 | Debug read index |
| dbgData | output | 96 | Debug read data |
| ovf | output | 4 | Per-lane signed overflow flags |

## Verification
The overflow flags are combinational, so they are due in the cycle the operands are applied. The bench drives inputs on the falling edge and samples `ovf` one nanosecond later, before the next rising edge. Register contents change only at the rising edge that sees the strobe. The bench therefore reads the destination through the debug port one nanosecond after that edge and compares it with its own shadow copy of the file. That shadow copy is updated from the requirements at the same point in time.

// File: rtl/vsa_pkg.sv
package vsa_pkg;
  localparam int LANES = 4;

  typedef struct packed {
    logic             addWr;
    logic             extWr;
    logic [LANES-1:0] laneWe;
    logic [LANES-1:0] flagEn;
  } vsaStrobe_t;
endpackage

// File: rtl/vsa_ctrl.sv
module vsa_ctrl
  import vsa_pkg::*;
(
  input  logic             valid,
  input  logic             extWr,
  input  logic [LANES-1:0] wrMask,
  output vsaStrobe_t       strb
);
  always_comb begin
    strb.addWr  = valid;
    strb.extWr  = extWr & ~valid;
    strb.laneWe = (valid | extWr) ? wrMask : '0;
    strb.flagEn = valid ? wrMask : '0;
  end
endmodule

// File: rtl/vsa_dp.sv
module vsa_dp
  import vsa_pkg::*;
#(
  parameter int NREGS  = 32,
  parameter int LANE_W = 24,
  localparam int IDX_W = $clog2(NREGS),
  localparam int SEL_W = $clog2(LANES),
  localparam int REG_W = LANES * LANE_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  vsaStrobe_t             strb,
  input  logic [IDX_W-1:0]       srcA,
  input  logic [IDX_W-1:0]       srcB,
  input  logic [IDX_W-1:0]       dst,
  input  logic [LANES*SEL_W-1:0] swzA,
  input  logic [LANES*SEL_W-1:0] swzB,
  input  logic [REG_W-1:0]       extData,
  input  logic [IDX_W-1:0]       dbgIdx,
  output logic [REG_W-1:0]       dbgData,
  output logic [LANES-1:0]       ovf
);
  localparam int MSB = LANE_W - 1;

  logic [REG_W-1:0] regs [NREGS];
  logic [REG_W-1:0] rdA, rdB, rdDst;
  logic [REG_W-1:0] tmpA, tmpB, sumVec, wrData;
  logic [LANES-1:0] laneOvf;

  assign rdA     = regs[srcA];
  assign rdB     = regs[srcB];
  assign rdDst   = regs[dst];
  assign dbgData = regs[dbgIdx];

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign tmpA[i*LANE_W +: LANE_W] = rdA[int'(swzA[i*SEL_W +: SEL_W])*LANE_W +: LANE_W];
    assign tmpB[i*LANE_W +: LANE_W] = rdB[int'(swzB[i*SEL_W +: SEL_W])*LANE_W +: LANE_W];
    assign sumVec[i*LANE_W +: LANE_W] = tmpA[i*LANE_W +: LANE_W] + tmpB[i*LANE_W +: LANE_W];
    assign laneOvf[i] = (tmpA[i*LANE_W+MSB] == tmpB[i*LANE_W+MSB]) &&
                        (sumVec[i*LANE_W+MSB] != tmpA[i*LANE_W+MSB]);
    assign ovf[i]     = strb.flagEn[i] & laneOvf[i];
    assign wrData[i*LANE_W +: LANE_W] = strb.addWr ? sumVec[i*LANE_W +: LANE_W]
                                                   : extData[i*LANE_W +: LANE_W];

    AST_LANE_WRITE: assert property (@(posedge clk) disable iff (rst)
      (strb.addWr && strb.laneWe[i]) |=>
        regs[$past(dst)][i*LANE_W +: LANE_W] == $past(sumVec[i*LANE_W +: LANE_W])); // R4
    AST_LANE_HOLD: assert property (@(posedge clk) disable iff (rst)
      (!strb.laneWe[i]) |=>
        regs[$past(dst)][i*LANE_W +: LANE_W] == $past(rdDst[i*LANE_W +: LANE_W])); // R5
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < NREGS; r++) regs[r] <= '0;
    end else begin
      for (int k = 0; k < LANES; k++)
        if (strb.laneWe[k]) regs[dst][k*LANE_W +: LANE_W] <= wrData[k*LANE_W +: LANE_W];
    end
  end

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (rdDst == '0 && dbgData == '0)); // R9
  AST_IDLE_NOWRITE: assert property (@(posedge clk) disable iff (rst)
    (!strb.addWr && !strb.extWr) |=> regs[$past(dst)] == $past(rdDst)); // R10
  AST_EXT_LOAD: assert property (@(posedge clk) disable iff (rst)
    (strb.extWr && strb.laneWe == '1) |=> regs[$past(dst)] == $past(extData)); // R11
endmodule

// File: rtl/swz_vec_adder.sv
module swz_vec_adder
  import vsa_pkg::*;
#(
  parameter int NREGS  = 32,
  parameter int LANE_W = 24,
  localparam int IDX_W = $clog2(NREGS),
  localparam int SEL_W = $clog2(LANES),
  localparam int REG_W = LANES * LANE_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   valid,
  input  logic [IDX_W-1:0]       srcA,
  input  logic [IDX_W-1:0]       srcB,
  input  logic [IDX_W-1:0]       dst,
  input  logic [LANES*SEL_W-1:0] swzA,
  input  logic [LANES*SEL_W-1:0] swzB,
  input  logic [LANES-1:0]       wrMask,
  input  logic                   extWr,
  input  logic [REG_W-1:0]       extData,
  input  logic [IDX_W-1:0]       dbgIdx,
  output logic [REG_W-1:0]       dbgData,
  output logic [LANES-1:0]       ovf
);
  vsaStrobe_t strb;

  vsa_ctrl u_ctrl (
    .valid  (valid),
    .extWr  (extWr),
    .wrMask (wrMask),
    .strb   (strb)
  );

  vsa_dp #(.NREGS(NREGS), .LANE_W(LANE_W)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strb    (strb),
    .srcA    (srcA),
    .srcB    (srcB),
    .dst     (dst),
    .swzA    (swzA),
    .swzB    (swzB),
    .extData (extData),
    .dbgIdx  (dbgIdx),
    .dbgData (dbgData),
    .ovf     (ovf)
  );

  AST_FLAG_MASKED: assert property (@(posedge clk) disable iff (rst)
    (ovf & ~(wrMask & {LANES{valid}})) == '0); // R7
endmodule

// File: tb/swz_vec_adder_bench.sv
module swz_vec_adder_bench;
  typedef struct packed {
    logic [4:0] a, b, d;
    logic [7:0] sa, sb;
    logic [3:0] m;
  } vec_t;

  // swizzle codes: abab=44 bbaa=05 abcd=E4 dddd=FF aaaa=00 dcba=1B cccc=AA bbbb=55
  localparam vec_t VECS [6] = '{
    '{5'd1, 5'd2, 5'd4, 8'h44, 8'h05, 4'b0011},
    '{5'd2, 5'd2, 5'd5, 8'hE4, 8'hE4, 4'b1111},
    '{5'd2, 5'd3, 5'd2, 8'hFF, 8'h00, 4'b0101},
    '{5'd3, 5'd1, 5'd6, 8'hE4, 8'h1B, 4'b1010},
    '{5'd4, 5'd3, 5'd4, 8'hE4, 8'hE4, 4'b0000},
    '{5'd3, 5'd2, 5'd7, 8'hAA, 8'h55, 4'b1111}
  };

  logic clk = 0, rst = 1, valid = 0, extWr = 0;
  logic [4:0] srcA = 0, srcB = 0, dst = 0, dbgIdx = 0;
  logic [7:0] swzA = 0, swzB = 0;
  logic [3:0] wrMask = 0, ovf;
  logic [95:0] extData = 0, dbgData;
  logic [95:0] mdl [32];
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  swz_vec_adder u_swz_vec_adder (
    .clk(clk), .rst(rst), .valid(valid), .srcA(srcA), .srcB(srcB), .dst(dst),
    .swzA(swzA), .swzB(swzB), .wrMask(wrMask), .extWr(extWr), .extData(extData),
    .dbgIdx(dbgIdx), .dbgData(dbgData), .ovf(ovf)
  );

  task automatic chk(input string req, input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic runOp(input logic [4:0] a, b, d, input logic [7:0] sa, sb,
                       input logic [3:0] m, input logic v, e,
                       input logic [95:0] data, input string req);
    logic [95:0] nv;
    logic [3:0] expOvf;
    nv = mdl[d];
    for (int k = 0; k < 4; k++) begin
      logic [23:0] ta, tb;
      logic [24:0] s;
      ta = mdl[a][int'(sa[2*k +: 2])*24 +: 24];
      tb = mdl[b][int'(sb[2*k +: 2])*24 +: 24];
      s  = {ta[23], ta} + {tb[23], tb};
      expOvf[k] = v & m[k] & (s[24] != s[23]);
      if (m[k] && v) nv[k*24 +: 24] = s[23:0];
      else if (m[k] && e) nv[k*24 +: 24] = data[k*24 +: 24];
    end
    @(negedge clk);
    srcA = a; srcB = b; dst = d; swzA = sa; swzB = sb; wrMask = m;
    valid = v; extWr = e; extData = data; dbgIdx = d;
    #1;
    chk({req, " ovf"}, {92'd0, ovf}, {92'd0, expOvf});
    @(posedge clk);
    #1;
    valid = 0; extWr = 0;
    mdl[d] = nv;
    chk({req, " reg"}, dbgData, mdl[d]);
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int r = 0; r < 32; r++) mdl[r] = '0;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    for (int r = 0; r < 32; r += 5) begin
      dbgIdx = r[4:0]; #1;
      chk("R9 reset state", dbgData, 96'd0);
    end
    // R11 / R1: load sources, lane a at bits [23:0]
    runOp(0, 0, 1, 0, 0, 4'hF, 0, 1, {24'h000004, 24'h000003, 24'h000002, 24'h000001}, "R11 R1 load");
    dbgIdx = 1; #1;
    chk("R1 lane a position", {72'd0, dbgData[23:0]}, 96'd1);
    runOp(0, 0, 2, 0, 0, 4'hF, 0, 1, {24'h7FFFFF, 24'h800000, 24'h400000, 24'h000010}, "R11 load");
    runOp(0, 0, 3, 0, 0, 4'hF, 0, 1, {24'hFFFFFF, 24'h123456, 24'h7FFFF0, 24'h000020}, "R11 load");
    // R2 R3 R4 R5 R6 R8: table walk
    for (int i = 0; i < 6; i++)
      runOp(VECS[i].a, VECS[i].b, VECS[i].d, VECS[i].sa, VECS[i].sb, VECS[i].m,
            1, 0, 96'd0, $sformatf("R2 R3 R4 R5 R6 R8 vec%0d", i));
    // R10 and R7: idle with overflowing operands and full mask
    runOp(2, 2, 1, 8'hFF, 8'hFF, 4'hF, 0, 0, 96'd0, "R10 R7 idle");
    // R11: valid has priority over the load
    runOp(1, 1, 8, 8'hE4, 8'hE4, 4'hF, 1, 1, {96{1'b1}}, "R11 priority");
    // R11 / R5: partial load, only lane c
    runOp(0, 0, 8, 0, 0, 4'b0100, 0, 1, {24'h0, 24'hABCDEF, 24'h0, 24'h0}, "R11 R5 partial");
    // R6: negative overflow in lane a, R8 dst equals srcB
    runOp(2, 2, 2, 8'h02, 8'h02, 4'b0001, 1, 0, 96'd0, "R6 R8 negative");
    // R9: reset in mid-run
    @(negedge clk); rst = 1;
    @(posedge clk); #1 rst = 0;
    for (int r = 1; r < 9; r++) begin
      dbgIdx = r[4:0]; #1;
      chk("R9 mid-run reset", dbgData, 96'd0);
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule